// File: doc/BRIEF.md
# Exclusive Access Monitor

This block tracks one reservation for a single core so that a load-linked / store-conditional pair can be built on a plain synchronous memory. The core hands it one request at a time, already decoded. Each request gives a direction (exclusive load or exclusive store), an access size, the outcome of the instruction's condition check, a byte address, a destination register index and up to two source words. An exclusive load reads memory and returns the data. It also records the address and sets the exclusive flag. An exclusive store writes memory only while that reservation is still valid for the same address. It then reports a status word of 0 on success or 1 on failure.

A doubleword access moves two consecutive words, at the address and at the address plus one word. Only the base address takes part in the reservation. Narrow accesses use byte enables on a word-wide memory port. Loads select the addressed lane and zero-extend it. A load whose destination is the program-counter register raises a redirect flag with its response, so that the core can refetch.

Top module: `exmon_unit`

## Requirements
- R1: After reset the exclusive flag is clear, `reqReady` is 1 and `rspValid` is 0, so the first exclusive store after reset returns status 1 and performs no memory write.
- R2: An exclusive store (`reqStore`=1, condition passed) whose address equals the address of the last exclusive load, with the exclusive flag set, writes memory and returns `rspData0`=0 with `rspWrEn`=1.
- R3: A successful exclusive store clears the exclusive flag, so a second store to the same address with no load in between fails.
- R4: A failing exclusive store makes no memory access, returns `rspData0`=1, and leaves both the reservation and the flag as they were.
- R5: A store to an address other than the reserved one fails, and a later store to the reserved address still succeeds.
- R6: `reqSize` encodes 0=byte, 1=halfword, 2=word, 3=doubleword. Byte and halfword stores write only the low 8 or 16 bits of `reqData0`, into the lane that `reqAddr[1:0]` selects, through `memBe`. Byte and halfword loads return that lane zero-extended in `rspData0`.
- R7: A doubleword load returns the word at the address in `rspData0` and the word at address+4 in `rspData1`, with `rspPair`=1 to signal a write to the register pair.
- R8: A doubleword store writes `reqData0` to the address and `reqData1` to address+4. Only the base address is reserved and compared, so a reservation made at address+4 does not let a doubleword store at the base succeed.
- R9: A request with `reqCondOk`=0 makes no memory access and leaves the reservation unchanged. It is answered with `rspValid`=1 and `rspWrEn`=0.
- R10: An exclusive load whose destination index is 15 sets `rspRedirect` together with its response. No other response sets it.
- R11: `reqReady` is 1 only while the monitor is idle. Each accepted request yields exactly one `rspValid` pulse, and the memory port performs at most one access per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Monitor idle and able to accept a request |
| reqStore | input | 1 | 1 = exclusive store, 0 = exclusive load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| reqCondOk | input | 1 | Condition check passed |
| reqAddr | input | AW | Byte address |
| reqDst | input | RW | Destination register index |
| reqData0 | input | DW | Store data (first source register) |
| reqData1 | input | DW | Store data for the second doubleword half |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | AW | Word-aligned memory address |
| memBe | output | DW/8 | Byte enables for writes |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Read data, valid one cycle after a read |
| rspValid | output | 1 | Response pulse |
| rspWrEn | output | 1 | Destination register must be written |
| rspPair | output | 1 | Second register of the pair must also be written |
| rspReg | output | RW | Destination register index |
| rspData0 | output | DW | Load data or store status |
| rspData1 | output | DW | Upper doubleword load data |
| rspRedirect | output | 1 | Load targeted the program counter |

## Verification
The assertions check on every cycle that a memory write begins only while the flag is set and the stored address matches, and that the flag is clear in the cycle after such a write. They also check that byte writes enable a single lane, that a store response carries a 0 or 1 status, that a redirect appears only with a valid load response to register 15, and that the port never carries two accesses at once. What the assertions cannot show is the sequence effect: which store fails after another store or after a condition-failed load, whether data lands in the right lane, and whether the upper doubleword word goes to memory. The bench scenarios show these by keeping a reference memory and reservation and comparing them with the responses and with the memory contents after every request.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_LDLO,
    ST_LDHI,
    ST_STHI
  } ctlState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic latchReq;
    logic issueRd0;
    logic issueRd1;
    logic capLo;
    logic capHi;
    logic wrBase;
    logic wrHigh;
    logic setRsv;
    logic clrRsv;
    logic stFail;
    logic finish;
  } ctlStrobe_t;

endpackage

// File: rtl/exmon_ctrl.sv
module exmon_ctrl
  import exmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       condQ,
  input  logic       storeQ,
  input  logic [1:0] sizeQ,
  input  logic       storeOk,
  output ctlStrobe_t ctl
);

  ctlState_e state, stateNxt;
  logic isDword;

  assign isDword = (sizeQ == SZ_DWORD);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    reqReady = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateNxt     = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (!condQ) begin
          ctl.finish = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (!storeQ) begin
          ctl.issueRd0 = 1'b1;
          ctl.setRsv   = 1'b1;
          stateNxt     = ST_LDLO;
        end else if (storeOk) begin
          ctl.wrBase = 1'b1;
          ctl.clrRsv = 1'b1;
          if (isDword) begin
            stateNxt = ST_STHI;
          end else begin
            ctl.finish = 1'b1;
            stateNxt   = ST_IDLE;
          end
        end else begin
          ctl.stFail = 1'b1;
          ctl.finish = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      ST_LDLO: begin
        ctl.capLo = 1'b1;
        if (isDword) begin
          ctl.issueRd1 = 1'b1;
          stateNxt     = ST_LDHI;
        end else begin
          ctl.finish = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      ST_LDHI: begin
        ctl.capHi  = 1'b1;
        ctl.finish = 1'b1;
        stateNxt   = ST_IDLE;
      end
      ST_STHI: begin
        ctl.wrHigh = 1'b1;
        ctl.finish = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.issueRd0, ctl.issueRd1, ctl.wrBase, ctl.wrHigh})); // R11
  AST_COND_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC && !condQ) |=> (state == ST_IDLE)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state != ST_IDLE) |-> !reqReady); // R11

endmodule

// File: rtl/exmon_datapath.sv
module exmon_datapath
  import exmon_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int RW           = 4,
  parameter int REDIRECT_REG = 15
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      ctl,
  input  logic            reqStore,
  input  logic [1:0]      reqSize,
  input  logic            reqCondOk,
  input  logic [AW-1:0]   reqAddr,
  input  logic [RW-1:0]   reqDst,
  input  logic [DW-1:0]   reqData0,
  input  logic [DW-1:0]   reqData1,
  output logic            condQ,
  output logic            storeQ,
  output logic [1:0]      sizeQ,
  output logic            storeOk,
  output logic            memReq,
  output logic            memWe,
  output logic [AW-1:0]   memAddr,
  output logic [DW/8-1:0] memBe,
  output logic [DW-1:0]   memWdata,
  input  logic [DW-1:0]   memRdata,
  output logic            rspValid,
  output logic            rspWrEn,
  output logic            rspPair,
  output logic [RW-1:0]   rspReg,
  output logic [DW-1:0]   rspData0,
  output logic [DW-1:0]   rspData1,
  output logic            rspRedirect
);

  localparam int LANES      = DW / 8;
  localparam int LB         = $clog2(LANES);
  localparam int WORD_BYTES = LANES;

  logic [AW-1:0] addrQ;
  logic [RW-1:0] dstQ;
  logic [DW-1:0] d0Q, d1Q;
  logic          rsvValid;
  logic [AW-1:0] rsvAddr;
  logic          rspIsStore;

  logic [LB-1:0]    laneOff;
  logic [AW-1:0]    baseAddr, highAddr;
  logic [LANES-1:0] baseBe;
  logic [DW-1:0]    baseWdata;
  logic [DW-1:0]    rdShift, rdLane;

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      condQ  <= 1'b0;
      storeQ <= 1'b0;
      sizeQ  <= SZ_WORD;
      addrQ  <= '0;
      dstQ   <= '0;
      d0Q    <= '0;
      d1Q    <= '0;
    end else if (ctl.latchReq) begin
      condQ  <= reqCondOk;
      storeQ <= reqStore;
      sizeQ  <= reqSize;
      addrQ  <= reqAddr;
      dstQ   <= reqDst;
      d0Q    <= reqData0;
      d1Q    <= reqData1;
    end
  end

  // Reservation and exclusive flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsvValid <= 1'b0;
      rsvAddr  <= '0;
    end else if (ctl.setRsv) begin
      rsvValid <= 1'b1;
      rsvAddr  <= addrQ;
    end else if (ctl.clrRsv) begin
      rsvValid <= 1'b0;
    end
  end

  assign storeOk = rsvValid && (rsvAddr == addrQ);

  // Address and lane steering
  assign laneOff  = addrQ[LB-1:0];
  assign baseAddr = {addrQ[AW-1:LB], {LB{1'b0}}};
  assign highAddr = baseAddr + AW'(WORD_BYTES);

  always_comb begin
    case (sizeQ)
      SZ_BYTE: begin
        baseBe    = LANES'(1) << laneOff;
        baseWdata = {LANES{d0Q[7:0]}};
      end
      SZ_HALF: begin
        baseBe    = LANES'(3) << {laneOff[LB-1:1], 1'b0};
        baseWdata = {(LANES/2){d0Q[15:0]}};
      end
      default: begin
        baseBe    = '1;
        baseWdata = d0Q;
      end
    endcase
  end

  assign rdShift = memRdata >> {laneOff, 3'b000};

  always_comb begin
    case (sizeQ)
      SZ_BYTE: rdLane = {{(DW-8){1'b0}}, rdShift[7:0]};
      SZ_HALF: rdLane = {{(DW-16){1'b0}}, rdShift[15:0]};
      default: rdLane = memRdata;
    endcase
  end

  // Memory port
  always_comb begin
    memReq   = 1'b0;
    memWe    = 1'b0;
    memAddr  = baseAddr;
    memBe    = '0;
    memWdata = '0;
    if (ctl.issueRd0) begin
      memReq = 1'b1;
    end else if (ctl.issueRd1) begin
      memReq  = 1'b1;
      memAddr = highAddr;
    end else if (ctl.wrBase) begin
      memReq   = 1'b1;
      memWe    = 1'b1;
      memBe    = baseBe;
      memWdata = baseWdata;
    end else if (ctl.wrHigh) begin
      memReq   = 1'b1;
      memWe    = 1'b1;
      memAddr  = highAddr;
      memBe    = '1;
      memWdata = d1Q;
    end
  end

  // Response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspWrEn     <= 1'b0;
      rspPair     <= 1'b0;
      rspReg      <= '0;
      rspRedirect <= 1'b0;
      rspIsStore  <= 1'b0;
      rspData0    <= '0;
      rspData1    <= '0;
    end else begin
      rspValid <= ctl.finish;
      if (ctl.finish) begin
        rspWrEn     <= condQ;
        rspPair     <= condQ && !storeQ && (sizeQ == SZ_DWORD);
        rspReg      <= dstQ;
        rspRedirect <= condQ && !storeQ && (dstQ == RW'(REDIRECT_REG));
        rspIsStore  <= condQ && storeQ;
      end else begin
        rspWrEn     <= 1'b0;
        rspPair     <= 1'b0;
        rspRedirect <= 1'b0;
        rspIsStore  <= 1'b0;
      end
      if (ctl.capLo)
        rspData0 <= rdLane;
      else if (ctl.finish && condQ && storeQ)
        rspData0 <= DW'(ctl.stFail);
      if (ctl.capHi)
        rspData1 <= memRdata;
    end
  end

  AST_WRITE_NEEDS_RSV: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !$past(memWe)) |-> (rsvValid && rsvAddr == addrQ)); // R2
  AST_RSV_GONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !$past(memWe)) |=> !rsvValid); // R3
  AST_STATUS_BINARY: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspIsStore) |-> (rspData0 <= DW'(1))); // R4
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !$past(memWe) && sizeQ == SZ_BYTE) |-> ($countones(memBe) == 1)); // R6
  AST_REDIRECT_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    rspRedirect |-> (rspValid && rspWrEn && !rspIsStore && rspReg == RW'(REDIRECT_REG))); // R10

endmodule

// File: rtl/exmon_unit.sv
module exmon_unit
  import exmon_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int RW           = 4,
  parameter int REDIRECT_REG = 15
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic            reqStore,
  input  logic [1:0]      reqSize,
  input  logic            reqCondOk,
  input  logic [AW-1:0]   reqAddr,
  input  logic [RW-1:0]   reqDst,
  input  logic [DW-1:0]   reqData0,
  input  logic [DW-1:0]   reqData1,
  output logic            memReq,
  output logic            memWe,
  output logic [AW-1:0]   memAddr,
  output logic [DW/8-1:0] memBe,
  output logic [DW-1:0]   memWdata,
  input  logic [DW-1:0]   memRdata,
  output logic            rspValid,
  output logic            rspWrEn,
  output logic            rspPair,
  output logic [RW-1:0]   rspReg,
  output logic [DW-1:0]   rspData0,
  output logic [DW-1:0]   rspData1,
  output logic            rspRedirect
);

  ctlStrobe_t ctl;
  logic       condQ, storeQ, storeOk;
  logic [1:0] sizeQ;

  exmon_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .condQ    (condQ),
    .storeQ   (storeQ),
    .sizeQ    (sizeQ),
    .storeOk  (storeOk),
    .ctl      (ctl)
  );

  exmon_datapath #(
    .AW(AW), .DW(DW), .RW(RW), .REDIRECT_REG(REDIRECT_REG)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqStore    (reqStore),
    .reqSize     (reqSize),
    .reqCondOk   (reqCondOk),
    .reqAddr     (reqAddr),
    .reqDst      (reqDst),
    .reqData0    (reqData0),
    .reqData1    (reqData1),
    .condQ       (condQ),
    .storeQ      (storeQ),
    .sizeQ       (sizeQ),
    .storeOk     (storeOk),
    .memReq      (memReq),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memBe       (memBe),
    .memWdata    (memWdata),
    .memRdata    (memRdata),
    .rspValid    (rspValid),
    .rspWrEn     (rspWrEn),
    .rspPair     (rspPair),
    .rspReg      (rspReg),
    .rspData0    (rspData0),
    .rspData1    (rspData1),
    .rspRedirect (rspRedirect)
  );

endmodule

// File: tb/exmon_unit_tb.sv
`timescale 1ns/1ps
module exmon_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0, reqCondOk = 1'b0;
  logic [1:0]  reqSize = 2'd2;
  logic [31:0] reqAddr = '0, reqData0 = '0, reqData1 = '0;
  logic [3:0]  reqDst = '0;
  logic        reqReady, memReq, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  memBe;
  logic        rspValid, rspWrEn, rspPair, rspRedirect;
  logic [3:0]  rspReg;
  logic [31:0] rspData0, rspData1;

  int nChecks = 0;
  int nErr = 0;

  logic [31:0] mem    [16];
  logic [31:0] refMem [16];
  bit          refRsv = 1'b0;
  logic [31:0] refRsvAddr = '0;
  logic [31:0] lastLoadAddr = 32'd8;

  always #2.5 clk = ~clk;

  exmon_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqStore(reqStore), .reqSize(reqSize), .reqCondOk(reqCondOk),
    .reqAddr(reqAddr), .reqDst(reqDst), .reqData0(reqData0), .reqData1(reqData1),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .rspValid(rspValid),
    .rspWrEn(rspWrEn), .rspPair(rspPair), .rspReg(rspReg),
    .rspData0(rspData0), .rspData1(rspData1), .rspRedirect(rspRedirect)
  );

  // Synchronous memory model
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[5:2]][8*b +: 8] <= memWdata[8*b +: 8];
      end else begin
        memRdata <= mem[memAddr[5:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] laneOf(input logic [31:0] w, input logic [1:0] sz,
                                         input logic [1:0] off);
    logic [31:0] s = w >> (8 * off);
    if (sz == 2'd0) return {24'd0, s[7:0]};
    if (sz == 2'd1) return {16'd0, s[15:0]};
    return w;
  endfunction

  task automatic doOp(input bit st, input logic [1:0] sz, input bit cond,
                      input logic [31:0] addr, input logic [3:0] dst,
                      input logic [31:0] d0, input logic [31:0] d1, input string tag);
    int w = int'(addr[5:2]);
    logic [1:0] off = addr[1:0];
    bit expOk = st && cond && refRsv && (refRsvAddr == addr);
    int expAcc;
    logic [31:0] expD0, expD1;
    int acc = 0;
    bit got = 0;
    int bad = 0;
    if (!cond) expAcc = 0;
    else if (!st || expOk) expAcc = (sz == 2'd3) ? 2 : 1;
    else expAcc = 0;
    expD0 = st ? (expOk ? 32'd0 : 32'd1) : laneOf(refMem[w], sz, off);
    expD1 = refMem[(w + 1) % 16];
    if (cond) begin
      if (!st) begin
        refRsv = 1'b1; refRsvAddr = addr; lastLoadAddr = addr;
      end else if (expOk) begin
        refRsv = 1'b0;
        case (sz)
          2'd0: refMem[w][8*off +: 8] = d0[7:0];
          2'd1: refMem[w][16*off[1] +: 16] = d0[15:0];
          2'd2: refMem[w] = d0;
          default: begin refMem[w] = d0; refMem[(w + 1) % 16] = d1; end
        endcase
      end
    end
    @(negedge clk);
    chk(reqReady == 1'b1, "R11", "ready when idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqStore = st; reqSize = sz; reqCondOk = cond;
    reqAddr = addr; reqDst = dst; reqData0 = d0; reqData1 = d1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      if (rspValid) begin got = 1; break; end
      acc += int'(memReq);
    end
    chk(got, "R11", "response seen", 32'(got), 32'd1);
    if (!got) return;
    chk(acc == expAcc, cond ? tag : "R9", "memory accesses", 32'(acc), 32'(expAcc));
    chk(rspWrEn == cond, cond ? tag : "R9", "rspWrEn", 32'(rspWrEn), 32'(cond));
    if (cond) begin
      chk(rspReg == dst, tag, "rspReg", 32'(rspReg), 32'(dst));
      chk(rspData0 == expD0, tag, st ? "status" : "load data", rspData0, expD0);
      chk(rspPair == (!st && sz == 2'd3), "R7", "rspPair", 32'(rspPair),
          32'(!st && sz == 2'd3));
      if (!st && sz == 2'd3)
        chk(rspData1 == expD1, "R7", "upper load word", rspData1, expD1);
    end
    chk(rspRedirect == (cond && !st && dst == 4'd15), "R10", "redirect",
        32'(rspRedirect), 32'(cond && !st && dst == 4'd15));
    for (int i = 0; i < 16; i++) if (mem[i] !== refMem[i]) bad++;
    chk(bad == 0, st ? (expOk ? tag : "R4") : tag, "memory contents", 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog R11: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'hA500_0000 ^ (32'h0101_0101 * i) ^ (i << 4);
      refMem[i] = mem[i];
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(rspValid == 1'b0, "R1", "rspValid after reset", 32'(rspValid), 32'd0);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", 32'(reqReady), 32'd1);
    // R1: first store after reset fails
    doOp(1, 2'd2, 1, 32'h00, 4'd1, 32'hDEAD_BEEF, 0, "R1");
    // R2 / R3
    doOp(0, 2'd2, 1, 32'h08, 4'd2, 0, 0, "R2");
    doOp(1, 2'd2, 1, 32'h08, 4'd3, 32'h1234_5678, 0, "R2");
    doOp(1, 2'd2, 1, 32'h08, 4'd3, 32'h8765_4321, 0, "R3");
    // R5: mismatch keeps reservation
    doOp(0, 2'd2, 1, 32'h10, 4'd4, 0, 0, "R5");
    doOp(1, 2'd2, 1, 32'h14, 4'd5, 32'h0BAD_0BAD, 0, "R5");
    doOp(1, 2'd2, 1, 32'h10, 4'd5, 32'h600D_600D, 0, "R5");
    // R6: narrow lanes
    doOp(0, 2'd0, 1, 32'h21, 4'd6, 0, 0, "R6");
    doOp(1, 2'd0, 1, 32'h21, 4'd6, 32'hABCD_1234, 0, "R6");
    doOp(0, 2'd1, 1, 32'h22, 4'd7, 0, 0, "R6");
    doOp(1, 2'd1, 1, 32'h22, 4'd7, 32'hFFFF_9ABC, 0, "R6");
    doOp(0, 2'd1, 1, 32'h22, 4'd7, 0, 0, "R6");
    // R7 / R8: doubleword
    doOp(0, 2'd3, 1, 32'h28, 4'd8, 0, 0, "R7");
    doOp(1, 2'd3, 1, 32'h28, 4'd8, 32'h1111_2222, 32'h3333_4444, "R8");
    doOp(0, 2'd2, 1, 32'h2C, 4'd8, 0, 0, "R8");
    doOp(1, 2'd3, 1, 32'h28, 4'd8, 32'h5555_6666, 32'h7777_8888, "R8");
    // R9: condition-failed requests change nothing
    doOp(0, 2'd2, 1, 32'h30, 4'd9, 0, 0, "R9");
    doOp(1, 2'd2, 0, 32'h30, 4'd9, 32'hCAFE_0001, 0, "R9");
    doOp(0, 2'd2, 0, 32'h34, 4'd9, 0, 0, "R9");
    doOp(1, 2'd2, 1, 32'h30, 4'd9, 32'hCAFE_0002, 0, "R9");
    // R10: redirect
    doOp(0, 2'd2, 1, 32'h04, 4'd15, 0, 0, "R10");
    doOp(0, 2'd2, 1, 32'h04, 4'd3, 0, 0, "R10");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      bit st = 1'($urandom % 2);
      logic [1:0] sz = 2'($urandom % 4);
      bit cond = ($urandom % 8) != 0;
      logic [31:0] a;
      a = 32'((2 + ($urandom % 4)) * 4);
      if (sz == 2'd0) a = a + 32'($urandom % 4);
      else if (sz == 2'd1) a = a + 32'(2 * ($urandom % 2));
      if (st && ($urandom % 2) == 0) begin
        a = lastLoadAddr;
        sz = (a[1:0] == 2'd0) ? sz : (a[0] ? 2'd0 : 2'd1);
      end
      doOp(st, sz, cond, a, 4'($urandom % 16), $urandom, $urandom,
           st ? "R2" : (sz == 2'd3 ? "R7" : "R6"));
    end
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule